// File: doc/BRIEF.md
# AXI4-Lite to APB Peripheral Bridge

This block is a slave on an AXI4-Lite fabric. It turns each single-beat read or write into one APB transfer aimed at one of up to sixteen peripherals. The peripherals sit side by side in one address window owned by the bridge. The window is cut into equal regions of `2**OFFSET_W` bytes. Four address bits just above the per-region offset pick the peripheral. The address bits above those must match the window base.

Each of the three request channels (write address, write data and read address) feeds a one-entry holding stage. That stage's ready output is high exactly while the stage is empty. A master that sees ready low keeps VALID and its payload steady until ready returns. A write starts on APB only once both its address and its data are held. When a read and a write are both waiting, the bridge alternates between them. A response stays valid until the master takes it, and the bridge starts no APB transfer while a response is waiting. A master that holds BREADY or RREADY low therefore stalls the peripheral side and, in the end, all three request channels.

Top module: `axil_periph_bridge`

## Requirements
- R1: After reset, AWREADY, WREADY and ARREADY are high, BVALID and RVALID are low, and every PSEL bit and PENABLE are low.
- R2: For an address inside the window, the peripheral index is address bits [OFFSET_W+3:OFFSET_W]. Exactly one PSEL bit (that index) is raised, and PADDR carries address bits [OFFSET_W-1:0].
- R3: Every APB transfer has exactly one setup cycle (PSEL high, PENABLE low), followed by access cycles with PENABLE high until the selected PREADY is sampled high. PSEL, PADDR and PWDATA stay stable throughout.
- R4: A write drives PWRITE=1, PWDATA=WDATA and PSTRB=WSTRB. It answers BRESP=2'b00 (OKAY) when PSLVERR is low at completion.
- R5: A read drives PWRITE=0 and returns the selected peripheral's PRDATA on RDATA with RRESP=2'b00 (OKAY).
- R6: PSLVERR sampled high together with PREADY gives a response of 2'b10 (SLVERR) on BRESP or RRESP.
- R7: An index of NUM_SLV or more, or address bits above the index that differ from WIN_BASE, gives a response of 2'b11 (DECERR) with RDATA zero and no PSEL activity at all.
- R8: A write's APB transfer starts only after both its address and its data have been accepted. Either one may arrive first.
- R9: With a read and a write both waiting, the one of the other kind than the last one granted wins. After reset a write wins.
- R10: BVALID/RVALID stay high, and BRESP/RRESP/RDATA stay stable, until the matching READY is high. No APB transfer starts meanwhile.
- R11: Each request channel holds one entry. Its READY stays low while that entry waits, for example behind an unaccepted response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address holding stage empty |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte lane enables, one per 8 data bits |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data holding stage empty |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Master accepts write response |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address holding stage empty |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Master accepts read response |
| m_psel | output | NUM_SLV | One select per peripheral |
| m_penable | output | 1 | Access phase marker |
| m_pwrite | output | 1 | Transfer direction, 1 = write |
| m_paddr | output | OFFSET_W | Offset inside the selected region |
| m_pwdata | output | DATA_W | Write data to peripheral |
| m_pstrb | output | DATA_W/8 | Byte lane enables to peripheral, zero on reads |
| m_prdata | input | NUM_SLV*DATA_W | Read data, peripheral i at bits [i*DATA_W +: DATA_W] |
| m_pready | input | NUM_SLV | Per-peripheral transfer completion |
| m_pslverr | input | NUM_SLV | Per-peripheral error flag, valid with PREADY |

## Verification
A wrong sequencer state shows on the peripheral side within one cycle. Symptoms are a PENABLE without a setup cycle, a select that changes during wait states, two selects at once, or a transfer that starts while a response is still being offered. A corrupted response register shows as a BRESP/RRESP or RDATA that changes while the master holds READY low, or a wrong code in the cycle the response is offered. A holding stage that loses or duplicates an entry shows as a missing or extra APB transfer, or as a READY that stays low one or more cycles after the stage should have drained. A wrong arbitration flag shows as reversed transfer order the next time a read and a write wait together.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } lpb_state_e;

  localparam logic [1:0] RSP_OKAY   = 2'b00;
  localparam logic [1:0] RSP_SLVERR = 2'b10;
  localparam logic [1:0] RSP_DECERR = 2'b11;

  // width of the peripheral index field in the address
  localparam int IDX_W = 4;

endpackage

// File: rtl/lpb_hold.sv
// One-entry holding stage for a valid/ready request channel.
module lpb_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);

  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/lpb_decode.sv
// Splits an address into peripheral index and offset and checks the window.
module lpb_decode
  import lpb_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              OFFSET_W = 12,
  parameter int              NUM_SLV  = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [IDX_W-1:0]    idx,
  output logic [OFFSET_W-1:0] offset,
  output logic                hit
);

  localparam int UP_W = ADDR_W - OFFSET_W - IDX_W;
  localparam logic [IDX_W:0] SLV_LIM = (IDX_W+1)'(NUM_SLV);

  logic win_ok;

  assign idx    = addr[OFFSET_W +: IDX_W];
  assign offset = addr[OFFSET_W-1:0];

  generate
    if (UP_W > 0) begin : g_win
      assign win_ok = (addr[ADDR_W-1 -: UP_W] == WIN_BASE[ADDR_W-1 -: UP_W]);
    end else begin : g_nowin
      assign win_ok = 1'b1;
    end
  endgenerate

  assign hit = win_ok && ({1'b0, idx} < SLV_LIM);

endmodule

// File: rtl/lpb_seq.sv
// Arbitration and APB phase sequencing for one transaction at a time.
module lpb_seq
  import lpb_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                NUM_SLV  = 4,
  parameter int                OFFSET_W = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = '0,
  localparam int               STRB_W   = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_pend,
  input  logic                      rd_pend,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [STRB_W-1:0]         wr_strb,
  output logic                      take_wr,
  output logic                      take_rd,
  output logic [NUM_SLV-1:0]        psel,
  output logic                      penable,
  output logic                      pwrite,
  output logic [OFFSET_W-1:0]       paddr,
  output logic [DATA_W-1:0]         pwdata,
  output logic [STRB_W-1:0]         pstrb,
  input  logic [NUM_SLV*DATA_W-1:0] prdata,
  input  logic [NUM_SLV-1:0]        pready,
  input  logic [NUM_SLV-1:0]        pslverr,
  output logic                      bvalid,
  input  logic                      bready,
  output logic [1:0]                bresp,
  output logic                      rvalid,
  input  logic                      rready,
  output logic [1:0]                rresp,
  output logic [DATA_W-1:0]         rdata
);

  lpb_state_e          state;
  logic                is_wr;
  logic                last_wr;
  logic [IDX_W-1:0]    cur_idx;
  logic [OFFSET_W-1:0] cur_off;
  logic [DATA_W-1:0]   cur_data;
  logic [STRB_W-1:0]   cur_strb;
  logic [1:0]          rsp_q;
  logic [DATA_W-1:0]   rdat_q;

  logic                grant_wr, grant_rd;
  logic [ADDR_W-1:0]   sel_addr;
  logic [IDX_W-1:0]    nxt_idx;
  logic [OFFSET_W-1:0] nxt_off;
  logic                nxt_hit;
  logic                active;
  logic                sel_ready, sel_err;
  logic [DATA_W-1:0]   sel_rdata;

  // alternate when both kinds wait; write first out of reset
  assign grant_wr = (state == ST_IDLE) && wr_pend && (!rd_pend || !last_wr);
  assign grant_rd = (state == ST_IDLE) && rd_pend && !grant_wr;
  assign take_wr  = grant_wr;
  assign take_rd  = grant_rd;
  assign sel_addr = grant_wr ? wr_addr : rd_addr;

  lpb_decode #(
    .ADDR_W  (ADDR_W),
    .OFFSET_W(OFFSET_W),
    .NUM_SLV (NUM_SLV),
    .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr  (sel_addr),
    .idx   (nxt_idx),
    .offset(nxt_off),
    .hit   (nxt_hit)
  );

  assign active = (state == ST_SETUP) || (state == ST_ACCESS);

  generate
    for (genvar g = 0; g < NUM_SLV; g++) begin : g_sel
      assign psel[g] = active && (cur_idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    sel_ready = 1'b0;
    sel_err   = 1'b0;
    sel_rdata = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (cur_idx == IDX_W'(i)) begin
        sel_ready = pready[i];
        sel_err   = pslverr[i];
        sel_rdata = prdata[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_wr    <= 1'b0;
      last_wr  <= 1'b0;
      cur_idx  <= '0;
      cur_off  <= '0;
      cur_data <= '0;
      cur_strb <= '0;
      rsp_q    <= RSP_OKAY;
      rdat_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (grant_wr || grant_rd) begin
            is_wr    <= grant_wr;
            last_wr  <= grant_wr;
            cur_idx  <= nxt_idx;
            cur_off  <= nxt_off;
            cur_data <= grant_wr ? wr_data : '0;
            cur_strb <= grant_wr ? wr_strb : '0;
            rdat_q   <= '0;
            if (nxt_hit) begin
              state <= ST_SETUP;
            end else begin
              rsp_q <= RSP_DECERR;
              state <= ST_RESP;
            end
          end
        end
        ST_SETUP: state <= ST_ACCESS;
        ST_ACCESS: begin
          if (sel_ready) begin
            rsp_q  <= sel_err ? RSP_SLVERR : RSP_OKAY;
            rdat_q <= is_wr ? '0 : sel_rdata;
            state  <= ST_RESP;
          end
        end
        ST_RESP: begin
          if ((is_wr && bready) || (!is_wr && rready)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign penable = (state == ST_ACCESS);
  assign pwrite  = is_wr;
  assign paddr   = cur_off;
  assign pwdata  = cur_data;
  assign pstrb   = cur_strb;
  assign bvalid  = (state == ST_RESP) && is_wr;
  assign rvalid  = (state == ST_RESP) && !is_wr;
  assign bresp   = rsp_q;
  assign rresp   = rsp_q;
  assign rdata   = rdat_q;

endmodule

// File: rtl/axil_periph_bridge.sv
module axil_periph_bridge
  import lpb_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                NUM_SLV  = 4,
  parameter int                OFFSET_W = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  localparam int               STRB_W   = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         s_awaddr,
  input  logic                      s_awvalid,
  output logic                      s_awready,
  input  logic [DATA_W-1:0]         s_wdata,
  input  logic [STRB_W-1:0]         s_wstrb,
  input  logic                      s_wvalid,
  output logic                      s_wready,
  output logic [1:0]                s_bresp,
  output logic                      s_bvalid,
  input  logic                      s_bready,
  input  logic [ADDR_W-1:0]         s_araddr,
  input  logic                      s_arvalid,
  output logic                      s_arready,
  output logic [DATA_W-1:0]         s_rdata,
  output logic [1:0]                s_rresp,
  output logic                      s_rvalid,
  input  logic                      s_rready,
  output logic [NUM_SLV-1:0]        m_psel,
  output logic                      m_penable,
  output logic                      m_pwrite,
  output logic [OFFSET_W-1:0]       m_paddr,
  output logic [DATA_W-1:0]         m_pwdata,
  output logic [STRB_W-1:0]         m_pstrb,
  input  logic [NUM_SLV*DATA_W-1:0] m_prdata,
  input  logic [NUM_SLV-1:0]        m_pready,
  input  logic [NUM_SLV-1:0]        m_pslverr
);

  logic              aw_full, w_full, ar_full;
  logic              take_wr, take_rd;
  logic [ADDR_W-1:0] aw_q, ar_q;
  logic [DATA_W+STRB_W-1:0] w_q;

  lpb_hold #(.W(ADDR_W)) u_aw_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_awvalid), .in_ready(s_awready), .in_data(s_awaddr),
    .take(take_wr), .full(aw_full), .data(aw_q)
  );

  lpb_hold #(.W(DATA_W+STRB_W)) u_w_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_wvalid), .in_ready(s_wready), .in_data({s_wdata, s_wstrb}),
    .take(take_wr), .full(w_full), .data(w_q)
  );

  lpb_hold #(.W(ADDR_W)) u_ar_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_arvalid), .in_ready(s_arready), .in_data(s_araddr),
    .take(take_rd), .full(ar_full), .data(ar_q)
  );

  lpb_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_SLV (NUM_SLV),
    .OFFSET_W(OFFSET_W),
    .WIN_BASE(WIN_BASE)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_pend(aw_full && w_full),
    .rd_pend(ar_full),
    .wr_addr(aw_q),
    .rd_addr(ar_q),
    .wr_data(w_q[DATA_W+STRB_W-1:STRB_W]),
    .wr_strb(w_q[STRB_W-1:0]),
    .take_wr(take_wr),
    .take_rd(take_rd),
    .psel   (m_psel),
    .penable(m_penable),
    .pwrite (m_pwrite),
    .paddr  (m_paddr),
    .pwdata (m_pwdata),
    .pstrb  (m_pstrb),
    .prdata (m_prdata),
    .pready (m_pready),
    .pslverr(m_pslverr),
    .bvalid (s_bvalid),
    .bready (s_bready),
    .bresp  (s_bresp),
    .rvalid (s_rvalid),
    .rready (s_rready),
    .rresp  (s_rresp),
    .rdata  (s_rdata)
  );

endmodule

// File: rtl/axil_periph_bridge_checker.sv
module axil_periph_bridge_checker #(
  parameter int NUM_SLV  = 4,
  parameter int DATA_W   = 32,
  parameter int OFFSET_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_SLV-1:0]  psel,
  input logic                penable,
  input logic [NUM_SLV-1:0]  pready,
  input logic [OFFSET_W-1:0] paddr,
  input logic [DATA_W-1:0]   pwdata,
  input logic                bvalid,
  input logic                bready,
  input logic [1:0]          bresp,
  input logic                rvalid,
  input logic                rready,
  input logic [1:0]          rresp,
  input logic [DATA_W-1:0]   rdata
);

  assert_psel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(psel));

  assert_enable_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    penable |-> (psel != '0));

  assert_setup_then_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((psel != '0) && !penable) |=> (penable && $stable(psel) && $stable(paddr)));

  assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (penable && ((psel & pready) == '0)) |=>
      (penable && $stable(psel) && $stable(paddr) && $stable(pwdata)));

  assert_bresp_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bresp)));

  assert_rresp_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rresp) && $stable(rdata)));

  assert_quiet_while_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid || rvalid) |-> (psel == '0));

  assert_single_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bvalid && rvalid));

endmodule

bind axil_periph_bridge axil_periph_bridge_checker #(
  .NUM_SLV (NUM_SLV),
  .DATA_W  (DATA_W),
  .OFFSET_W(OFFSET_W)
) u_checker (
  .clk    (clk),
  .rst_n  (rst_n),
  .psel   (m_psel),
  .penable(m_penable),
  .pready (m_pready),
  .paddr  (m_paddr),
  .pwdata (m_pwdata),
  .bvalid (s_bvalid),
  .bready (s_bready),
  .bresp  (s_bresp),
  .rvalid (s_rvalid),
  .rready (s_rready),
  .rresp  (s_rresp),
  .rdata  (s_rdata)
);

// File: tb/axil_periph_bridge_bench.sv
module axil_periph_bridge_bench;

  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b1;
  logic [31:0] s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b1;
  logic [NS-1:0]    m_psel;
  logic             m_penable, m_pwrite;
  logic [11:0]      m_paddr;
  logic [31:0]      m_pwdata;
  logic [3:0]       m_pstrb;
  logic [NS*32-1:0] m_prdata;
  logic [NS-1:0]    m_pready = '0;
  logic [NS-1:0]    m_pslverr = '0;

  always #5 clk = ~clk;

  axil_periph_bridge u_axil_periph_bridge (.*);

  // peripheral read data: pattern C0DE, index, offset
  for (genvar i = 0; i < NS; i++) begin : g_prd
    assign m_prdata[i*32 +: 32] = {16'hC0DE, 4'(i), m_paddr};
  end

  // peripheral model and APB monitor
  int          wait_cyc = 0;
  logic [NS-1:0] err_mask = '0;
  int          acc = 0;
  int          tr_n = 0, psel_cyc = 0, setup_cyc = 0, access_cyc = 0;
  logic        tr_write [64];
  logic [NS-1:0] tr_sel [64];
  logic [11:0] tr_addr [64];
  logic [31:0] tr_data [64];
  logic [3:0]  tr_strb [64];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pready = '0; m_pslverr = '0; acc = 0;
    end else begin
      if (m_psel != '0) psel_cyc++;
      if (m_psel != '0 && !m_penable) setup_cyc++;
      if (m_psel != '0 && m_penable) begin
        access_cyc++;
        if (acc == wait_cyc) begin
          m_pready = m_psel; m_pslverr = err_mask & m_psel; acc = 0;
          if (tr_n < 64) begin
            tr_write[tr_n] = m_pwrite; tr_sel[tr_n] = m_psel; tr_addr[tr_n] = m_paddr;
            tr_data[tr_n] = m_pwdata; tr_strb[tr_n] = m_pstrb;
          end
          tr_n++;
        end else begin
          m_pready = '0; m_pslverr = '0; acc++;
        end
      end else begin
        m_pready = '0; m_pslverr = '0; acc = 0;
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; s_awvalid = 0; s_wvalid = 0; s_arvalid = 0; s_bready = 1; s_rready = 1;
    wait_cyc = 0; err_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_aw(input logic [31:0] a);
    s_awaddr = a; s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk); s_awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk); s_wvalid = 1'b0;
  endtask

  task automatic send_ar(input logic [31:0] a);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk); s_arvalid = 1'b0;
  endtask

  task automatic axi_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    fork
      send_aw(a);
      send_w(d, s);
    join
  endtask

  task automatic get_b(output logic [1:0] r);
    while (!s_bvalid) @(negedge clk);
    r = s_bresp;
    @(negedge clk);
  endtask

  task automatic get_r(output logic [1:0] r, output logic [31:0] d);
    while (!s_rvalid) @(negedge clk);
    r = s_rresp; d = s_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "awready", s_awready, 1);
    chk("R1", "wready", s_wready, 1);
    chk("R1", "arready", s_arready, 1);
    chk("R1", "b/rvalid", {s_bvalid, s_rvalid}, 0);
    chk("R1", "psel/penable", {m_psel, m_penable}, 0);
  endtask

  task automatic t_write_basic();
    int b = tr_n, su = setup_cyc, ac = access_cyc;
    logic [1:0] r;
    wait_cyc = 3;
    axi_write(32'h4000_2010, 32'hDEAD_BEEF, 4'b0101);
    get_b(r);
    chk("R4", "bresp okay", r, 2'b00);
    chk("R2", "transfer count", tr_n - b, 1);
    chk("R2", "psel index 2", tr_sel[b], 4'b0100);
    chk("R2", "paddr offset", tr_addr[b], 12'h010);
    chk("R4", "pwrite", tr_write[b], 1);
    chk("R4", "pwdata", tr_data[b], 32'hDEAD_BEEF);
    chk("R4", "pstrb passthrough", tr_strb[b], 4'b0101);
    chk("R3", "one setup cycle", setup_cyc - su, 1);
    chk("R3", "access cycles with 3 waits", access_cyc - ac, 4);
    wait_cyc = 0;
  endtask

  task automatic t_read_basic();
    int b = tr_n, ac = access_cyc;
    logic [1:0] r; logic [31:0] d;
    send_ar(32'h4000_1ABC);
    get_r(r, d);
    chk("R5", "rresp okay", r, 2'b00);
    chk("R5", "rdata from slave 1", d, 32'hC0DE_1ABC);
    chk("R5", "pwrite low", tr_write[b], 0);
    chk("R5", "pstrb zero on read", tr_strb[b], 0);
    chk("R3", "single access cycle", access_cyc - ac, 1);
  endtask

  task automatic t_error();
    logic [1:0] r; logic [31:0] d;
    err_mask = 4'b1000;
    axi_write(32'h4000_3000, 32'h1234_5678, 4'hF);
    get_b(r);
    chk("R6", "bresp slverr", r, 2'b10);
    send_ar(32'h4000_3004);
    get_r(r, d);
    chk("R6", "rresp slverr", r, 2'b10);
    err_mask = '0;
    send_ar(32'h4000_2004);
    get_r(r, d);
    chk("R6", "other slave okay", r, 2'b00);
  endtask

  task automatic t_decerr();
    int b = tr_n, pc = psel_cyc;
    logic [1:0] r; logic [31:0] d;
    axi_write(32'h4000_5000, 32'hAAAA_5555, 4'hF);
    get_b(r);
    chk("R7", "bresp decerr index", r, 2'b11);
    send_ar(32'h4000_F000);
    get_r(r, d);
    chk("R7", "rresp decerr index", r, 2'b11);
    chk("R7", "rdata zero", d, 0);
    send_ar(32'h5000_1000);
    get_r(r, d);
    chk("R7", "rresp decerr window", r, 2'b11);
    chk("R7", "no psel activity", psel_cyc - pc, 0);
    chk("R7", "no transfers", tr_n - b, 0);
  endtask

  task automatic t_split();
    int b = tr_n, pc = psel_cyc;
    logic [1:0] r;
    send_aw(32'h4000_0020);
    repeat (6) @(negedge clk);
    chk("R8", "no APB with address only", psel_cyc - pc, 0);
    send_w(32'h0BAD_F00D, 4'b1100);
    get_b(r);
    chk("R8", "addr-first transfer", {tr_addr[b], tr_data[b]}, {12'h020, 32'h0BAD_F00D});
    pc = psel_cyc;
    send_w(32'h7777_0001, 4'b0011);
    repeat (6) @(negedge clk);
    chk("R8", "no APB with data only", psel_cyc - pc, 0);
    send_aw(32'h4000_1030);
    get_b(r);
    chk("R8", "data-first transfer", {tr_sel[b+1], tr_addr[b+1], tr_data[b+1]},
        {4'b0010, 12'h030, 32'h7777_0001});
  endtask

  task automatic t_arb();
    int b;
    logic [1:0] r1, r2; logic [31:0] d;
    do_reset();
    b = tr_n;
    fork
      axi_write(32'h4000_1000, 32'h1111_0000, 4'hF);
      send_ar(32'h4000_2000);
    join
    fork get_b(r1); get_r(r2, d); join
    chk("R9", "write first after reset", {tr_write[b], tr_write[b+1]}, 2'b10);
    axi_write(32'h4000_1004, 32'h2222_0000, 4'hF);
    get_b(r1);
    b = tr_n;
    fork
      axi_write(32'h4000_1008, 32'h3333_0000, 4'hF);
      send_ar(32'h4000_2008);
    join
    fork get_b(r1); get_r(r2, d); join
    chk("R9", "read first after write", {tr_write[b], tr_write[b+1]}, 2'b01);
    chk("R5", "rdata after arbitration", d, 32'hC0DE_2008);
  endtask

  task automatic t_hold();
    int rec, pc;
    logic [1:0] b0, r1, r2; logic [31:0] d;
    s_bready = 1'b0;
    axi_write(32'h4000_0100, 32'h5555_AAAA, 4'hF);
    while (!s_bvalid) @(negedge clk);
    rec = tr_n; pc = psel_cyc; b0 = s_bresp;
    fork
      axi_write(32'h4000_1200, 32'h6666_0000, 4'hF);
      send_ar(32'h4000_2300);
    join
    chk("R11", "awready low while held", s_awready, 0);
    chk("R11", "wready low while held", s_wready, 0);
    chk("R11", "arready low while held", s_arready, 0);
    repeat (8) @(negedge clk);
    chk("R10", "bvalid held", s_bvalid, 1);
    chk("R10", "bresp stable", s_bresp, b0);
    chk("R10", "no APB while response waits", psel_cyc - pc, 0);
    s_bready = 1'b1;
    get_b(r1);
    chk("R10", "held bresp okay", r1, 2'b00);
    fork get_b(r1); get_r(r2, d); join
    chk("R9", "queued read before queued write", {tr_write[rec], tr_write[rec+1]}, 2'b01);
    chk("R5", "queued read data", d, 32'hC0DE_2300);
    chk("R11", "stages drained", {s_awready, s_wready, s_arready}, 3'b111);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_write_basic();
    t_read_basic();
    t_error();
    t_decerr();
    t_split();
    t_arb();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule